// File: doc/BRIEF.md
# Bus Arbiter Interrupt Status Logic

This block sits beside a bus arbiter that runs as the host bridge and records why the arbiter wants attention. It watches every grant. If the granted master does not start its transaction (FRAME active) in time, it raises a master-broken event. Other arbiter error detectors live elsewhere and reach this block as single-cycle pulses.

All events land in one status register whose bits are cleared by writing 1. Only the first event after the register empties is kept. A second register holds one enable bit per source. The single interrupt output is high while any recorded bit has its enable bit set. Software reads and writes both registers through a simple port. A low address bit selects the register, and reads return data in the same cycle.

Top module: `arb_irq_status`

## Requirements
- R1: After reset the status register and the enable register both read 0 and `irq_o` is low.
- R2: While `host_mode_i` is low, no event sets any status bit.
- R3: Only the first event is recorded. While any status bit is set, further events are dropped and their bits stay 0.
- R4: Writing to the status register (`addr_i` = 0) clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R5: Only bits 0 to NUM_EXT-1 (external pulse `evt_i[k]` maps to bit k) and bit 13 (master-broken) exist, in both registers. All other bits read 0 and ignore writes. The enable register is at `addr_i` = 1.
- R6: An event whose enable bit is 0 still sets its status bit, but `irq_o` stays low.
- R7: `irq_o` is high exactly when some status bit and its enable bit are both 1, and it stays high until software clears that status bit.
- R8: When several events arrive in the same cycle and the register is empty, only the highest-numbered bit is recorded.
- R9: A master-broken event (bit 13) is recorded when one grant is held with FRAME low for 16 consecutive sampled cycles. If FRAME is seen in one of those cycles, no event is raised.
- R10: The grant timer restarts when the grant moves to another master or is removed and given again. It fires at most once per grant.
- R11: In a cycle whose write clears the last set bit, a simultaneous event is dropped. An event in the following cycle is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| host_mode_i | input | 1 | High when the device acts as host bridge |
| gnt_i | input | NUM_MST | One-hot grant vector from the arbiter |
| frame_i | input | 1 | FRAME active (transaction started), active high |
| evt_i | input | NUM_EXT | Pulse inputs from the other error detectors |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 status, 1 enable |
| wr_data_i | input | REG_W | Write data |
| rd_data_o | output | REG_W | Read data of the selected register |
| irq_o | output | 1 | Interrupt request |

## Verification
Several properties are checked on every cycle. The status register never holds more than one bit. Nothing new appears while host mode is off. A write that covers every set bit empties the register. The interrupt never rises without a recorded bit. A master-broken pulse only follows a cycle in which the same grant was held without FRAME. Reserved read bits stay zero.

Other behaviours need the bench's scenarios. These are the exact 16-cycle boundary of the grant timer and its restart on a new grant. They also include the priority between events in the same cycle, the loss of an event during a clearing write followed by capture one cycle later, and the difference between a masked and an unmasked source.

// File: rtl/arb_irq_pkg.sv
package arb_irq_pkg;

   typedef enum logic {
      REG_STATUS = 1'b0,
      REG_ENABLE = 1'b1
   } arb_reg_e;

   // implemented-bit mask: external pulses at the bottom, master-broken at mb_bit
   function automatic logic [63:0] impl_mask(input int n_ext, input int mb_bit);
      logic [63:0] m;
      m = '0;
      for (int i = 0; i < 64; i++) begin
         if (i < n_ext) m[i] = 1'b1;
         if (i == mb_bit) m[i] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/arb_gnt_wdog.sv
module arb_gnt_wdog #(
   parameter int NUM_MST = 4,
   parameter int TIMEOUT = 16
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_MST-1:0] gnt_i,
   input  logic               frame_i,
   output logic               fire_o
);

   localparam int CNT_W = $clog2(TIMEOUT + 1);

   if (TIMEOUT < 2) begin : g_bad_timeout
      $error("arb_gnt_wdog: TIMEOUT must be at least 2");
   end
   if (NUM_MST < 1) begin : g_bad_mst
      $error("arb_gnt_wdog: NUM_MST must be at least 1");
   end

   logic [NUM_MST-1:0] gnt_q;
   logic [CNT_W-1:0]   cnt_q;
   logic               armed_q;
   logic               new_gnt;
   logic               held;

   assign new_gnt = (gnt_i != '0) && (gnt_i != gnt_q);
   assign held    = (gnt_i != '0) && !frame_i;
   assign fire_o  = armed_q && held && !new_gnt && (cnt_q == CNT_W'(TIMEOUT - 1));

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         gnt_q   <= '0;
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else begin
         gnt_q <= gnt_i;
         if (!held) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
         end else if (new_gnt) begin
            cnt_q   <= CNT_W'(1);
            armed_q <= 1'b1;
         end else if (fire_o) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
         end else if (armed_q) begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

   // R9
   wdog_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_o |-> ($past(!frame_i) && ($past(gnt_i) == gnt_i)));

   // R10
   wdog_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_o |=> !fire_o);

endmodule

// File: rtl/arb_src_capture.sv
module arb_src_capture #(
   parameter int               REG_W = 32,
   parameter logic [REG_W-1:0] IMPL  = '1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             host_mode_i,
   input  logic [REG_W-1:0] src_i,
   input  logic [REG_W-1:0] clr_i,
   output logic [REG_W-1:0] status_o
);

   logic [REG_W-1:0] status_q;
   logic [REG_W-1:0] pick;
   logic [REG_W-1:0] status_d;

   // fixed priority: the highest implemented bit wins
   always_comb begin
      pick = '0;
      for (int i = 0; i < REG_W; i++) begin
         if (src_i[i] && IMPL[i]) begin
            pick    = '0;
            pick[i] = 1'b1;
         end
      end
   end

   always_comb begin
      status_d = status_q & ~clr_i;
      if (host_mode_i && (status_q == '0)) status_d = status_d | pick;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) status_q <= '0;
      else         status_q <= status_d;
   end

   assign status_o = status_q;

   // R3
   single_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(status_q));

   // R2
   mode_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !host_mode_i |=> ((status_q & ~$past(status_q)) == '0));

   // R4
   clr_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((status_q != '0) && ((clr_i & status_q) == status_q)) |=> (status_q == '0));

endmodule

// File: rtl/arb_irq_mask.sv
module arb_irq_mask #(
   parameter int               REG_W    = 32,
   parameter logic [REG_W-1:0] IMPL     = '1,
   parameter bit               IRQ_FLOP = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_we_i,
   input  logic [REG_W-1:0] en_wdata_i,
   input  logic [REG_W-1:0] status_i,
   output logic [REG_W-1:0] enable_o,
   output logic             irq_o
);

   logic [REG_W-1:0] enable_q;
   logic             irq_raw;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)      enable_q <= '0;
      else if (en_we_i) enable_q <= en_wdata_i & IMPL;
   end

   assign enable_o = enable_q;
   assign irq_raw  = |(status_i & enable_q);

   if (IRQ_FLOP) begin : g_irq_flop
      logic irq_q;
      always_ff @(posedge clk_i) begin
         if (!rst_ni) irq_q <= 1'b0;
         else         irq_q <= irq_raw;
      end
      assign irq_o = irq_q;

      // R7
      irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         irq_o |-> ($past(status_i) != '0));
   end else begin : g_irq_comb
      assign irq_o = irq_raw;

      // R7
      irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         irq_o |-> (status_i != '0));
   end

endmodule

// File: rtl/arb_irq_status.sv
module arb_irq_status #(
   parameter int REG_W    = 32,
   parameter int NUM_EXT  = 6,
   parameter int MB_BIT   = 13,
   parameter int NUM_MST  = 4,
   parameter int TIMEOUT  = 16,
   parameter bit IRQ_FLOP = 1'b0
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               host_mode_i,
   input  logic [NUM_MST-1:0] gnt_i,
   input  logic               frame_i,
   input  logic [NUM_EXT-1:0] evt_i,
   input  logic               wr_en_i,
   input  logic               addr_i,
   input  logic [REG_W-1:0]   wr_data_i,
   output logic [REG_W-1:0]   rd_data_o,
   output logic               irq_o
);

   import arb_irq_pkg::*;

   localparam logic [REG_W-1:0] IMPL = REG_W'(impl_mask(NUM_EXT, MB_BIT));

   if (REG_W > 64 || REG_W < 2) begin : g_bad_width
      $error("arb_irq_status: REG_W must lie in 2..64");
   end
   if (MB_BIT >= REG_W) begin : g_bad_mb
      $error("arb_irq_status: MB_BIT outside the register");
   end
   if (NUM_EXT < 1 || NUM_EXT > MB_BIT) begin : g_bad_ext
      $error("arb_irq_status: external sources must sit below MB_BIT");
   end

   logic             mb_fire;
   logic [REG_W-1:0] src;
   logic [REG_W-1:0] clr;
   logic [REG_W-1:0] status;
   logic [REG_W-1:0] enable;
   logic             st_we;
   logic             en_we;

   arb_gnt_wdog #(
      .NUM_MST (NUM_MST),
      .TIMEOUT (TIMEOUT)
   ) wdog_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .gnt_i   (gnt_i),
      .frame_i (frame_i),
      .fire_o  (mb_fire)
   );

   always_comb begin
      src                = '0;
      src[NUM_EXT-1:0]   = evt_i;
      src[MB_BIT]        = mb_fire;
   end

   assign st_we = wr_en_i && (arb_reg_e'(addr_i) == REG_STATUS);
   assign en_we = wr_en_i && (arb_reg_e'(addr_i) == REG_ENABLE);
   assign clr   = st_we ? (wr_data_i & IMPL) : '0;

   arb_src_capture #(
      .REG_W (REG_W),
      .IMPL  (IMPL)
   ) cap_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .host_mode_i (host_mode_i),
      .src_i       (src),
      .clr_i       (clr),
      .status_o    (status)
   );

   arb_irq_mask #(
      .REG_W    (REG_W),
      .IMPL     (IMPL),
      .IRQ_FLOP (IRQ_FLOP)
   ) mask_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_we_i    (en_we),
      .en_wdata_i (wr_data_i),
      .status_i   (status),
      .enable_o   (enable),
      .irq_o      (irq_o)
   );

   assign rd_data_o = (arb_reg_e'(addr_i) == REG_ENABLE) ? enable : status;

   // R5
   rsvd_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_data_o & ~IMPL) == '0);

endmodule

// File: tb/arb_irq_status_tb_top.sv
module arb_irq_status_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int REG_W      = 32;
   localparam int NUM_EXT    = 6;
   localparam int NUM_MST    = 4;

   typedef struct {
      string            req;
      logic [REG_W-1:0] data;
      logic             irq;
   } exp_t;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               host_mode = 1'b0;
   logic [NUM_MST-1:0] gnt = '0;
   logic               frame = 1'b0;
   logic [NUM_EXT-1:0] evt = '0;
   logic               wr_en = 1'b0;
   logic               addr = 1'b0;
   logic [REG_W-1:0]   wr_data = '0;
   logic [REG_W-1:0]   rd_data;
   logic               irq;

   exp_t exp_q[$];
   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   arb_irq_status dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .host_mode_i (host_mode),
      .gnt_i       (gnt),
      .frame_i     (frame),
      .evt_i       (evt),
      .wr_en_i     (wr_en),
      .addr_i      (addr),
      .wr_data_i   (wr_data),
      .rd_data_o   (rd_data),
      .irq_o       (irq)
   );

   // monitor: pops expectations and compares at the falling edge
   always @(negedge clk) begin
      if (exp_q.size() != 0) begin
         exp_t e;
         e = exp_q.pop_front();
         n_chk++;
         if (rd_data !== e.data || irq !== e.irq) begin
            n_fail++;
            $display("FAIL %s: rd_data=%h irq=%b expected rd_data=%h irq=%b",
                     e.req, rd_data, irq, e.data, e.irq);
         end
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic expect_item(input string r, input logic a,
                              input logic [REG_W-1:0] d, input logic i);
      exp_t e;
      addr   = a;
      e.req  = r;
      e.data = d;
      e.irq  = i;
      exp_q.push_back(e);
      @(negedge clk);
      #1;
   endtask

   task automatic wr(input logic a, input logic [REG_W-1:0] d);
      wr_en = 1'b1; addr = a; wr_data = d;
      step(1);
      wr_en = 1'b0; wr_data = '0; addr = 1'b0;
   endtask

   task automatic pulse(input logic [NUM_EXT-1:0] m);
      evt = m;
      step(1);
      evt = '0;
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      expect_item("R1 status", 1'b0, 32'h0, 1'b0);
      expect_item("R1 enable", 1'b1, 32'h0, 1'b0);

      // R2: host mode off
      pulse(6'b000100);
      step(1);
      expect_item("R2", 1'b0, 32'h0, 1'b0);

      host_mode = 1'b1;
      // R5: reserved enable bits
      wr(1'b1, 32'hFFFF_FFFF);
      expect_item("R5 enable", 1'b1, 32'h0000_203F, 1'b0);

      // R7 / R3
      pulse(6'b000010);
      expect_item("R7 irq", 1'b0, 32'h2, 1'b1);
      pulse(6'b010000);
      step(2);
      expect_item("R3 first only", 1'b0, 32'h2, 1'b1);

      // R4 / R5
      wr(1'b0, 32'h0);
      expect_item("R4 zero write", 1'b0, 32'h2, 1'b1);
      wr(1'b0, 32'hFFFF_DFC0);
      expect_item("R5 reserved status write", 1'b0, 32'h2, 1'b1);
      wr(1'b0, 32'h2);
      expect_item("R4 clear", 1'b0, 32'h0, 1'b0);

      // R8: same-cycle priority
      pulse(6'b100001);
      expect_item("R8 priority", 1'b0, 32'h20, 1'b1);
      wr(1'b0, 32'h20);

      // R6: disabled source
      wr(1'b1, 32'h1);
      pulse(6'b001000);
      expect_item("R6 masked", 1'b0, 32'h8, 1'b0);
      wr(1'b0, 32'h8);
      wr(1'b1, 32'h203F);

      // R9: FRAME on the 16th cycle prevents the event
      gnt = 4'b0001;
      step(15);
      frame = 1'b1;
      step(3);
      expect_item("R9 frame in time", 1'b0, 32'h0, 1'b0);
      gnt = '0; frame = 1'b0;
      step(2);

      // R9: 16 cycles without FRAME
      gnt = 4'b0001;
      step(15);
      expect_item("R9 cycle 15", 1'b0, 32'h0, 1'b0);
      gnt = '0;
      step(2);
      gnt = 4'b0001;
      step(16);
      expect_item("R9 timeout", 1'b0, 32'h2000, 1'b1);
      step(20);
      wr(1'b0, 32'h2000);
      step(20);
      expect_item("R10 once per grant", 1'b0, 32'h0, 1'b0);
      gnt = '0;
      step(2);

      // R10: grant moves to another master
      gnt = 4'b0001;
      step(10);
      gnt = 4'b0100;
      step(10);
      expect_item("R10 restart", 1'b0, 32'h0, 1'b0);
      step(6);
      expect_item("R10 after restart", 1'b0, 32'h2000, 1'b1);
      gnt = '0;
      wr(1'b0, 32'h2000);

      // R11: clear and event in the same cycle, then re-arm
      pulse(6'b000010);
      wr_en = 1'b1; addr = 1'b0; wr_data = 32'h2; evt = 6'b010000;
      step(1);
      wr_en = 1'b0; wr_data = '0; evt = '0;
      expect_item("R11 dropped", 1'b0, 32'h0, 1'b0);
      pulse(6'b010000);
      expect_item("R11 rearmed", 1'b0, 32'h10, 1'b1);

      step(2);
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule